// File: doc/BRIEF.md
# Twenty-Bit Accumulator ALU with Condition Flags

This block is the arithmetic and logic unit of a 20-bit accumulator processor. Each cycle it combines an accumulator value with a second operand, taken from memory or from an immediate field. A 3-bit operation code and a 1-bit column select choose the function. The result is combinational. The zero, sign and carry flags sit in a small register that loads on a rising clock edge only while the flag-enable input is high. Those flags feed the processor's condition tests.

The select bit picks one of two columns of eight operations. Column 0 holds the arithmetic group: add and subtract, with and without carry, plus an index add, exclusive OR and bit clear. Column 1 holds the less common logic functions (implication, equivalence, AND and OR) and the data transfers: load, store and store-complement. Code 4 is reserved in both columns. Data moves through the unit as two 10-bit bytes, and the carry ripples from the low byte into the high byte.

Top module: `alu20_flags`

## Requirements
- R1: Column 0, code 1 gives acc + opnd, and code 3 gives acc + opnd + stored carry. Both write the carry flag with the carry out of bit 19.
- R2: Column 0, code 0 gives acc + ~opnd + 1, and code 2 gives acc + ~opnd + stored carry. Both write the carry flag with the carry out of bit 19, so 1 means no borrow.
- R3: Column 0, code 5 (index add) gives acc + opnd and leaves the carry flag unchanged.
- R4: Column 0, code 6 gives acc ^ opnd, and code 7 (bit clear) gives acc & ~opnd.
- R5: Column 1 logic functions: code 0 gives ~acc | opnd (implication), code 1 gives ~(acc ^ opnd) (equivalence), code 3 gives acc & opnd, and code 6 gives acc | opnd.
- R6: Column 1 transfers: code 2 (load) gives opnd, code 5 (store) gives acc, and code 7 (store complement) gives ~acc.
- R7: For every code except 4, a rising edge with flag_en high sets zero_o to 1 exactly when all 20 result bits are 0, and sets sign_o to result bit 19.
- R8: Every column 1 operation and every column 0 code from 4 to 7 leaves the carry flag unchanged.
- R9: Code 4 in either column gives opnd unchanged and changes no flag.
- R10: While flag_en is low, no flag changes.
- R11: Reset (rst_n low) clears all three flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flags load on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_i | input | 20 | Accumulator operand |
| opnd_i | input | 20 | Memory or immediate operand |
| op_i | input | 3 | Operation code within the column |
| col_i | input | 1 | Column select |
| flag_en_i | input | 1 | Flag write enable |
| result_o | output | 20 | Combinational result |
| zero_o | output | 1 | Registered zero flag |
| sign_o | output | 1 | Registered sign flag |
| carry_o | output | 1 | Registered carry flag |

## Verification
An arithmetic operation can write all three flags in a single edge. Zero and carry can then be set together, and the carry value written in one cycle feeds the carry-in of the next operation. The bench provokes this case with 0xFFFFF + 1, which gives a zero result with a carry out. It follows that with add-with-carry and subtract-with-borrow in the next cycles, so the stored carry is consumed immediately. Each result is judged against an independent reference model. The registered flags are checked one edge later through a scoreboard queue.

// File: rtl/alu20_pkg.sv
package alu20_pkg;
    localparam int unsigned DATA_W = 20;
    localparam int unsigned BYTE_W = 10;

    typedef enum logic [1:0] {
        SRC_ADDER,
        SRC_LOGIC
    } src_e;

    typedef enum logic [3:0] {
        LG_XOR,
        LG_BIC,
        LG_IMP,
        LG_EQV,
        LG_AND,
        LG_OR,
        LG_OPND,
        LG_ACC,
        LG_NACC
    } logic_e;

    typedef enum logic [1:0] {
        CIN_ZERO,
        CIN_ONE,
        CIN_FLAG
    } cin_e;

    typedef struct packed {
        src_e   src;
        logic_e lsel;
        logic   inv_b;
        cin_e   cin;
        logic   wr_zs;
        logic   wr_c;
    } ctl_t;

    typedef struct packed {
        logic z;
        logic s;
        logic c;
    } flags_t;
endpackage

// File: rtl/alu20_decode.sv
module alu20_decode
    import alu20_pkg::*;
(
    input  logic [2:0] op_i,
    input  logic       col_i,
    output ctl_t       ctl_o
);
    ctl_t ctl_d;

    always_comb begin
        ctl_d       = '0;
        ctl_d.src   = SRC_LOGIC;
        ctl_d.lsel  = LG_OPND;
        ctl_d.inv_b = 1'b0;
        ctl_d.cin   = CIN_ZERO;
        ctl_d.wr_zs = 1'b1;
        ctl_d.wr_c  = 1'b0;
        if (!col_i) begin
            unique case (op_i)
                3'd0: begin ctl_d.src = SRC_ADDER; ctl_d.inv_b = 1'b1; ctl_d.cin = CIN_ONE;  ctl_d.wr_c = 1'b1; end
                3'd1: begin ctl_d.src = SRC_ADDER; ctl_d.cin = CIN_ZERO; ctl_d.wr_c = 1'b1; end
                3'd2: begin ctl_d.src = SRC_ADDER; ctl_d.inv_b = 1'b1; ctl_d.cin = CIN_FLAG; ctl_d.wr_c = 1'b1; end
                3'd3: begin ctl_d.src = SRC_ADDER; ctl_d.cin = CIN_FLAG; ctl_d.wr_c = 1'b1; end
                3'd4: begin ctl_d.lsel = LG_OPND; ctl_d.wr_zs = 1'b0; end
                3'd5: begin ctl_d.src = SRC_ADDER; ctl_d.cin = CIN_ZERO; end
                3'd6: ctl_d.lsel = LG_XOR;
                3'd7: ctl_d.lsel = LG_BIC;
                default: ctl_d.wr_zs = 1'b0;
            endcase
        end else begin
            unique case (op_i)
                3'd0: ctl_d.lsel = LG_IMP;
                3'd1: ctl_d.lsel = LG_EQV;
                3'd2: ctl_d.lsel = LG_OPND;
                3'd3: ctl_d.lsel = LG_AND;
                3'd4: begin ctl_d.lsel = LG_OPND; ctl_d.wr_zs = 1'b0; end
                3'd5: ctl_d.lsel = LG_ACC;
                3'd6: ctl_d.lsel = LG_OR;
                3'd7: ctl_d.lsel = LG_NACC;
                default: ctl_d.wr_zs = 1'b0;
            endcase
        end
    end

    assign ctl_o = ctl_d;
endmodule

// File: rtl/alu20_adder.sv
module alu20_adder #(
    parameter int unsigned DATA_W = 20,
    parameter int unsigned BYTE_W = 10
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              inv_b_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              cout_o
);
    localparam int unsigned NBYTES = DATA_W / BYTE_W;

    logic [DATA_W-1:0] b_eff;
    logic [NBYTES:0]   chain;

    assign b_eff    = inv_b_i ? ~b_i : b_i;
    assign chain[0] = cin_i;

    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        logic [BYTE_W:0] part;
        assign part = {1'b0, a_i[g*BYTE_W +: BYTE_W]}
                    + {1'b0, b_eff[g*BYTE_W +: BYTE_W]}
                    + {{BYTE_W{1'b0}}, chain[g]};
        assign sum_o[g*BYTE_W +: BYTE_W] = part[BYTE_W-1:0];
        assign chain[g+1] = part[BYTE_W];
    end

    assign cout_o = chain[NBYTES];
endmodule

// File: rtl/alu20_logic.sv
module alu20_logic
    import alu20_pkg::*;
#(
    parameter int unsigned DATA_W = 20
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic_e            sel_i,
    output logic [DATA_W-1:0] y_o
);
    always_comb begin
        unique case (sel_i)
            LG_XOR:  y_o = a_i ^ b_i;
            LG_BIC:  y_o = a_i & ~b_i;
            LG_IMP:  y_o = ~a_i | b_i;
            LG_EQV:  y_o = ~(a_i ^ b_i);
            LG_AND:  y_o = a_i & b_i;
            LG_OR:   y_o = a_i | b_i;
            LG_ACC:  y_o = a_i;
            LG_NACC: y_o = ~a_i;
            default: y_o = b_i;
        endcase
    end
endmodule

// File: rtl/alu20_flags.sv
module alu20_flags
    import alu20_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W,
    parameter int unsigned BYTE  = BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] acc_i,
    input  logic [WIDTH-1:0] opnd_i,
    input  logic [2:0]       op_i,
    input  logic             col_i,
    input  logic             flag_en_i,
    output logic [WIDTH-1:0] result_o,
    output logic             zero_o,
    output logic             sign_o,
    output logic             carry_o
);
    ctl_t             ctl;
    logic [WIDTH-1:0] sum;
    logic             cout;
    logic [WIDTH-1:0] lres;
    logic             cin;
    flags_t           flags_d, flags_q;

    alu20_decode u_decode (
        .op_i  (op_i),
        .col_i (col_i),
        .ctl_o (ctl)
    );

    always_comb begin
        unique case (ctl.cin)
            CIN_ONE:  cin = 1'b1;
            CIN_FLAG: cin = flags_q.c;
            default:  cin = 1'b0;
        endcase
    end

    alu20_adder #(.DATA_W(WIDTH), .BYTE_W(BYTE)) u_adder (
        .a_i     (acc_i),
        .b_i     (opnd_i),
        .inv_b_i (ctl.inv_b),
        .cin_i   (cin),
        .sum_o   (sum),
        .cout_o  (cout)
    );

    alu20_logic #(.DATA_W(WIDTH)) u_logic (
        .a_i   (acc_i),
        .b_i   (opnd_i),
        .sel_i (ctl.lsel),
        .y_o   (lres)
    );

    assign result_o = (ctl.src == SRC_ADDER) ? sum : lres;

    always_comb begin
        flags_d = flags_q;
        if (flag_en_i) begin
            if (ctl.wr_zs) begin
                flags_d.z = (result_o == '0);
                flags_d.s = result_o[WIDTH-1];
            end
            if (ctl.wr_c) begin
                flags_d.c = cout;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign zero_o  = flags_q.z;
    assign sign_o  = flags_q.s;
    assign carry_o = flags_q.c;

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_en_i |=> $stable({zero_o, sign_o, carry_o}));

    a_r9_reserved_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en_i && op_i == 3'd4) |=> $stable({zero_o, sign_o, carry_o}));

    a_r9_reserved_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd4) |-> (result_o == opnd_i));

    a_r8_carry_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en_i && (col_i || op_i[2])) |=> $stable(carry_o));

    a_r7_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en_i && op_i != 3'd4) |=> (zero_o == $past(result_o == '0)));

    a_r7_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en_i && op_i != 3'd4) |=> (sign_o == $past(result_o[WIDTH-1])));
endmodule

// File: tb/test_alu20_flags.sv
module test_alu20_flags;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] acc_i = '0, opnd_i = '0;
    logic [2:0]  op_i = '0;
    logic        col_i = 1'b0, flag_en_i = 1'b0;
    logic [19:0] result_o;
    logic        zero_o, sign_o, carry_o;

    int n_cmp = 0, n_bad = 0;
    logic mz = 1'b0, ms = 1'b0, mc = 1'b0;
    logic [2:0] exp_q[$];
    string tag_q[$];
    bit done = 1'b0;

    always #4 clk = ~clk;

    alu20_flags i_alu20_flags (
        .clk(clk), .rst_n(rst_n), .acc_i(acc_i), .opnd_i(opnd_i),
        .op_i(op_i), .col_i(col_i), .flag_en_i(flag_en_i),
        .result_o(result_o), .zero_o(zero_o), .sign_o(sign_o), .carry_o(carry_o)
    );

    task automatic check(string tag, logic [19:0] act, logic [19:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%05h expected=%05h", tag, act, exp);
        end
    endtask

    // driver: apply one operation, check the result, queue the expected flags
    task automatic drive(string tag, logic col, logic [2:0] op,
                         logic [19:0] a, logic [19:0] b, logic en);
        logic [20:0] s;
        logic [19:0] r;
        logic wzs, wc;
        @(negedge clk);
        acc_i = a; opnd_i = b; op_i = op; col_i = col; flag_en_i = en;
        wzs = 1'b1; wc = 1'b0; s = '0;
        if (!col) begin
            case (op)
                3'd0: begin s = {1'b0,a} + {1'b0,~b} + 21'd1; r = s[19:0]; wc = 1'b1; end
                3'd1: begin s = {1'b0,a} + {1'b0,b}; r = s[19:0]; wc = 1'b1; end
                3'd2: begin s = {1'b0,a} + {1'b0,~b} + {20'd0,mc}; r = s[19:0]; wc = 1'b1; end
                3'd3: begin s = {1'b0,a} + {1'b0,b} + {20'd0,mc}; r = s[19:0]; wc = 1'b1; end
                3'd4: begin r = b; wzs = 1'b0; end
                3'd5: begin s = {1'b0,a} + {1'b0,b}; r = s[19:0]; end
                3'd6: r = a ^ b;
                default: r = a & ~b;
            endcase
        end else begin
            case (op)
                3'd0: r = ~a | b;
                3'd1: r = ~(a ^ b);
                3'd2: r = b;
                3'd3: r = a & b;
                3'd4: begin r = b; wzs = 1'b0; end
                3'd5: r = a;
                3'd6: r = a | b;
                default: r = ~a;
            endcase
        end
        #1 check({tag, " result"}, result_o, r);
        if (en && wzs) begin mz = (r == 20'd0); ms = r[19]; end
        if (en && wc) mc = s[20];
        exp_q.push_back({mz, ms, mc});
        tag_q.push_back(tag);
    endtask

    // monitor: after each edge, compare the registered flags
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [2:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({t, " flags"}, {17'd0, zero_o, sign_o, carry_o}, {17'd0, e});
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 check("R11 reset flags", {17'd0, zero_o, sign_o, carry_o}, 20'd0);
        @(negedge clk) rst_n = 1'b1;
        // R1: add and add-with-carry; wrap gives zero and carry in one edge
        drive("R1 add", 1'b0, 3'd1, 20'h12345, 20'h00111, 1'b1);
        drive("R1 add wrap", 1'b0, 3'd1, 20'hFFFFF, 20'h00001, 1'b1);
        drive("R1 adc cin=1", 1'b0, 3'd3, 20'h003FF, 20'h00000, 1'b1);
        drive("R1 adc byte carry", 1'b0, 3'd3, 20'h003FF, 20'h00001, 1'b1);
        // R2: subtract, borrow, subtract-with-borrow
        drive("R2 sub equal", 1'b0, 3'd0, 20'h0ABCD, 20'h0ABCD, 1'b1);
        drive("R2 sub borrow", 1'b0, 3'd0, 20'h00001, 20'h00002, 1'b1);
        drive("R2 sbc borrow in", 1'b0, 3'd2, 20'h00010, 20'h00001, 1'b1);
        drive("R2 sbc no borrow in", 1'b0, 3'd2, 20'h00010, 20'h00001, 1'b1);
        // R3: index add keeps carry (currently set)
        drive("R3 adx", 1'b0, 3'd5, 20'hFFFFF, 20'h00002, 1'b1);
        // R4
        drive("R4 xor", 1'b0, 3'd6, 20'hF0F0F, 20'hFF00F, 1'b1);
        drive("R4 bit clear", 1'b0, 3'd7, 20'hFFFFF, 20'h0F0F0, 1'b1);
        // R5
        drive("R5 imp", 1'b1, 3'd0, 20'hFF000, 20'h0F0F0, 1'b1);
        drive("R5 eqv", 1'b1, 3'd1, 20'h12345, 20'h12345, 1'b1);
        drive("R5 and", 1'b1, 3'd3, 20'hF0F0F, 20'h0FFF0, 1'b1);
        drive("R5 or", 1'b1, 3'd6, 20'h80000, 20'h00001, 1'b1);
        // R6
        drive("R6 load zero", 1'b1, 3'd2, 20'h11111, 20'h00000, 1'b1);
        drive("R6 store", 1'b1, 3'd5, 20'h9ABCD, 20'h00000, 1'b1);
        drive("R6 store complement", 1'b1, 3'd7, 20'h9ABCD, 20'h55555, 1'b1);
        // R8: logic op after a carry-clearing op
        drive("R8 sub clears carry", 1'b0, 3'd0, 20'h00000, 20'h00001, 1'b1);
        drive("R8 or keeps carry", 1'b1, 3'd6, 20'h00000, 20'h00000, 1'b1);
        // R9: reserved in both columns
        drive("R9 reserved col0", 1'b0, 3'd4, 20'h12345, 20'h00000, 1'b1);
        drive("R9 reserved col1", 1'b1, 3'd4, 20'hFFFFF, 20'h80001, 1'b1);
        // R10: enable low
        drive("R10 hold add", 1'b0, 3'd1, 20'hFFFFF, 20'h00001, 1'b0);
        drive("R10 hold load", 1'b1, 3'd2, 20'h00000, 20'h00000, 1'b0);
        // R7: sign and zero from a plain add
        drive("R7 sign", 1'b0, 3'd1, 20'h7FFFF, 20'h00001, 1'b1);
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule